// File: doc/BRIEF.md
# Two-Level Address Translation Walker

The walker turns a 32-bit virtual address into a physical address by reading an in-memory translation structure of up to two levels. A request carries the virtual address and the table base. The walker reads one first-level word and decodes its type. It then either ends the walk at once (fault, 1 MB section or 16 MB super-section) or reads one second-level word from a coarse table (1 KB, 256 entries) or a fine table (4 KB, 1024 entries).

The second-level word describes a 64 KB large page, a 4 KB small page or a 1 KB tiny page, or it signals a fault. Each response returns the physical address, a two-bit permission field, the four-bit domain, the bufferable and cacheable bits, a mapping-kind code and a fault code. Large and small pages hold one permission field per quarter of the page, and the walker returns the field for the quarter being accessed.

Memory is reached through a single-word read port. The request side uses valid/ready and the data returns on a valid strobe. The walker handles one translation at a time and accepts the next request only after it has delivered the current response.

Top module: `xlat_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle, and one request is taken per handshake. The first memory read goes to `{req_tbase[31:14], va[31:20], 2'b00}`, so the low 14 bits of the table base are ignored.
- R2: A first-level word with type bits [1:0] = 00 ends the walk after one read. The response has `rsp_fault` = 01, `rsp_kind` = 0, and zero address, domain, permission and attribute outputs.
- R3: A first-level word with type 10 and bit 18 clear gives `rsp_kind` = 1 and `pa = {d[31:20], va[19:0]}`. It also gives domain d[8:5], permission d[11:10], bufferable d[2] and cacheable d[3], with `rsp_fault` = 00.
- R4: A type-10 word with bit 18 set gives `rsp_kind` = 2 and `pa = {d[31:24], va[23:0]}`. The other fields come from the same bits as in R3.
- R5: Type 01 (coarse) makes the second read at `{d[31:10], va[19:12], 2'b00}`. Type 11 (fine) makes it at `{d[31:12], va[19:10], 2'b00}`.
- R6: A second-level word with type 00 gives `rsp_fault` = 10, `rsp_kind` = 0, the first-level domain, and zero address, permission and attributes.
- R7: Second-level type 01 (large page) gives `rsp_kind` = 3 and `pa = {d[31:16], va[15:0]}`. The permission is field k = va[15:14], taken from bits [5+2k:4+2k].
- R8: Second-level type 10 (small page) gives `rsp_kind` = 4 and `pa = {d[31:12], va[11:0]}`. The permission is field k = va[11:10], taken from bits [5+2k:4+2k].
- R9: Second-level type 11 (tiny page) gives `rsp_kind` = 5 and `pa = {d[31:10], va[9:0]}`, with the permission from bits [5:4].
- R10: For every page result, bufferable is second-level bit 2, cacheable is second-level bit 3, and the domain is first-level bits [8:5].
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the next cycle keeps `mem_req_valid` high and `mem_addr` unchanged.
- R12: `rsp_valid` is high for exactly one cycle. The walker is idle (`req_ready` high) in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken |
| req_va | input | 32 | Virtual address |
| req_tbase | input | 32 | First-level table base (16 KB aligned) |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_addr | output | 32 | Word address of the read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rdata | input | 32 | Read data |
| rsp_valid | output | 1 | Response strobe |
| rsp_pa | output | 32 | Physical address |
| rsp_ap | output | 2 | Permission field |
| rsp_dom | output | 4 | Domain |
| rsp_buf | output | 1 | Bufferable |
| rsp_cache | output | 1 | Cacheable |
| rsp_kind | output | 3 | 0 fault, 1 section, 2 super-section, 3 large, 4 small, 5 tiny |
| rsp_fault | output | 2 | 00 none, 01 first-level, 10 second-level |

## Verification
A wrong state decode would show up during the walk itself. The number of memory reads or the second read address would be wrong before any response appears, so the bench compares both per walk. A wrong field slice or subpage select shows only in the one-cycle response. A sweep over every first-level type, every second-level type and all four quarter selects, with addresses computed in the bench, catches it on the first affected walk. A memory that stalls on a repeating pattern checks that the read request holds still while it waits.

// File: rtl/xlat_walker.sv
module xlat_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_va,
  input  logic [31:0] req_tbase,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_pa,
  output logic [1:0]  rsp_ap,
  output logic [3:0]  rsp_dom,
  output logic        rsp_buf,
  output logic        rsp_cache,
  output logic [2:0]  rsp_kind,
  output logic [1:0]  rsp_fault
);

  typedef enum logic [2:0] {IDLE, L1_REQ, L1_WAIT, L2_REQ, L2_WAIT, DONE} state_t;

  state_t      st;
  logic [31:0] va_q;
  logic [17:0] base_q;
  logic [31:0] l2a_q;
  logic [3:0]  dom_q;

  assign req_ready     = (st == IDLE);
  assign rsp_valid     = (st == DONE);
  assign mem_req_valid = (st == L1_REQ) || (st == L2_REQ);
  assign mem_addr      = (st == L2_REQ) ? l2a_q : {base_q, va_q[31:20], 2'b00};

  function automatic logic [1:0] quarter_ap(input logic [31:0] d, input logic [1:0] q);
    case (q)
      2'd0:    quarter_ap = d[5:4];
      2'd1:    quarter_ap = d[7:6];
      2'd2:    quarter_ap = d[9:8];
      default: quarter_ap = d[11:10];
    endcase
  endfunction

  wire [31:0] d = mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      va_q      <= '0;
      base_q    <= '0;
      l2a_q     <= '0;
      dom_q     <= '0;
      rsp_pa    <= '0;
      rsp_ap    <= '0;
      rsp_dom   <= '0;
      rsp_buf   <= 1'b0;
      rsp_cache <= 1'b0;
      rsp_kind  <= '0;
      rsp_fault <= '0;
    end else begin
      case (st)
        IDLE: if (req_valid) begin
          va_q   <= req_va;
          base_q <= req_tbase[31:14];
          st     <= L1_REQ;
        end
        L1_REQ: if (mem_req_ready) st <= L1_WAIT;
        L1_WAIT: if (mem_rsp_valid) begin
          dom_q     <= d[8:5];
          rsp_pa    <= '0;
          rsp_ap    <= '0;
          rsp_dom   <= '0;
          rsp_buf   <= 1'b0;
          rsp_cache <= 1'b0;
          rsp_kind  <= 3'd0;
          rsp_fault <= 2'b00;
          case (d[1:0])
            2'b00: begin
              rsp_fault <= 2'b01;
              st        <= DONE;
            end
            2'b10: begin
              rsp_dom   <= d[8:5];
              rsp_ap    <= d[11:10];
              rsp_buf   <= d[2];
              rsp_cache <= d[3];
              if (d[18]) begin
                rsp_pa   <= {d[31:24], va_q[23:0]};
                rsp_kind <= 3'd2;
              end else begin
                rsp_pa   <= {d[31:20], va_q[19:0]};
                rsp_kind <= 3'd1;
              end
              st <= DONE;
            end
            2'b01: begin
              l2a_q <= {d[31:10], va_q[19:12], 2'b00};
              st    <= L2_REQ;
            end
            default: begin
              l2a_q <= {d[31:12], va_q[19:10], 2'b00};
              st    <= L2_REQ;
            end
          endcase
        end
        L2_REQ: if (mem_req_ready) st <= L2_WAIT;
        L2_WAIT: if (mem_rsp_valid) begin
          rsp_dom   <= dom_q;
          rsp_buf   <= d[2];
          rsp_cache <= d[3];
          case (d[1:0])
            2'b00: begin
              rsp_fault <= 2'b10;
              rsp_kind  <= 3'd0;
              rsp_pa    <= '0;
              rsp_ap    <= '0;
              rsp_buf   <= 1'b0;
              rsp_cache <= 1'b0;
            end
            2'b01: begin
              rsp_pa   <= {d[31:16], va_q[15:0]};
              rsp_ap   <= quarter_ap(d, va_q[15:14]);
              rsp_kind <= 3'd3;
            end
            2'b10: begin
              rsp_pa   <= {d[31:12], va_q[11:0]};
              rsp_ap   <= quarter_ap(d, va_q[11:10]);
              rsp_kind <= 3'd4;
            end
            default: begin
              rsp_pa   <= {d[31:10], va_q[9:0]};
              rsp_ap   <= d[5:4];
              rsp_kind <= 3'd5;
            end
          endcase
          st <= DONE;
        end
        default: st <= IDLE;
      endcase
    end
  end

endmodule

module xlat_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_addr,
  input logic        rsp_valid,
  input logic [3:0]  rsp_dom,
  input logic [2:0]  rsp_kind,
  input logic [1:0]  rsp_fault
);
  a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr));
  a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);
  a_r1_one_walk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  a_r1_busy_reading: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);
  a_r2_l1_fault_fields: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault == 2'b01 |-> rsp_dom == 4'd0 && rsp_kind == 3'd0);
  a_r6_fault_kind: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != 2'b00 |-> rsp_kind == 3'd0);
endmodule

bind xlat_walker xlat_walker_chk u_chk (.*);

// File: tb/xlat_walker_bench.sv
module xlat_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic [31:0] req_tbase = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_pa;
  logic [1:0]  rsp_ap;
  logic [3:0]  rsp_dom;
  logic        rsp_buf;
  logic        rsp_cache;
  logic [2:0]  rsp_kind;
  logic [1:0]  rsp_fault;

  always #10 clk = ~clk;

  xlat_walker u_xlat_walker (.*);

  int checks = 0, errors = 0, hold_fail = 0;
  logic [31:0] cur_d1, cur_d2;
  int unsigned nrd = 0, walk_start = 0, cyc = 0, smod = 1;
  logic [31:0] a_log [0:1];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_req_ready <= ((cyc % smod) == 0);
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (nrd - walk_start < 2) a_log[nrd - walk_start] <= mem_addr;
      mem_rdata     <= (nrd == walk_start) ? cur_d1 : cur_d2;
      mem_rsp_valid <= 1'b1;
      nrd           <= nrd + 1;
    end
  end

  logic        pend = 1'b0;
  logic [31:0] pend_a = '0;
  always @(negedge clk) begin
    if (pend && !(mem_req_valid && mem_addr == pend_a)) begin
      hold_fail = hold_fail + 1;
      $display("FAIL R11 valid=%0b addr=%h exp valid=1 addr=%h", mem_req_valid, mem_addr, pend_a);
    end
    pend   = mem_req_valid && !mem_req_ready;
    pend_a = mem_addr;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] va, input logic [31:0] tb,
                      input logic [31:0] d1, input logic [31:0] d2);
    logic [31:0] e_pa, e_a2; logic [1:0] e_ap, e_flt; logic [3:0] e_dom;
    logic e_b, e_c; logic [2:0] e_kind; int e_nrd; string tag; bit got;
    e_pa = 0; e_ap = 0; e_dom = 0; e_b = 0; e_c = 0; e_kind = 0; e_flt = 0; e_a2 = 0;
    e_nrd = 1; tag = "R2";
    case (d1[1:0])
      2'd0: e_flt = 2'b01;
      2'd2: begin
        e_dom = d1[8:5]; e_ap = d1[11:10]; e_b = d1[2]; e_c = d1[3];
        if (d1[18]) begin e_pa = {d1[31:24], va[23:0]}; e_kind = 2; tag = "R4"; end
        else        begin e_pa = {d1[31:20], va[19:0]}; e_kind = 1; tag = "R3"; end
      end
      default: begin
        e_nrd = 2; e_dom = d1[8:5];
        e_a2 = (d1[1:0] == 2'd1) ? ((d1 & 32'hFFFFFC00) | ({24'd0, va[19:12]} << 2))
                                 : ((d1 & 32'hFFFFF000) | ({22'd0, va[19:10]} << 2));
        case (d2[1:0])
          2'd0: begin e_flt = 2'b10; tag = "R6"; end
          2'd1: begin e_pa = (d2 & 32'hFFFF0000) | (va & 32'h0000FFFF); e_kind = 3; tag = "R7";
                  e_ap = 2'((d2 >> (4 + 2 * va[15:14])) & 3); e_b = d2[2]; e_c = d2[3]; end
          2'd2: begin e_pa = (d2 & 32'hFFFFF000) | (va & 32'h00000FFF); e_kind = 4; tag = "R8";
                  e_ap = 2'((d2 >> (4 + 2 * va[11:10])) & 3); e_b = d2[2]; e_c = d2[3]; end
          default: begin e_pa = (d2 & 32'hFFFFFC00) | (va & 32'h000003FF); e_kind = 5; tag = "R9";
                  e_ap = d2[5:4]; e_b = d2[2]; e_c = d2[3]; end
        endcase
      end
    endcase
    @(negedge clk);
    cur_d1 = d1; cur_d2 = d2; walk_start = nrd;
    req_va = va; req_tbase = tb; req_valid = 1'b1;
    chk("R1 ready", 32'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    got = 0;
    for (int t = 0; t < 200 && !got; t++) begin
      if (rsp_valid) got = 1; else @(negedge clk);
    end
    if (!got) begin
      checks++; errors++;
      $display("FAIL R12 watchdog act=no response exp=response");
      return;
    end
    chk(tag, rsp_pa, e_pa);
    chk(tag, 32'(rsp_ap), 32'(e_ap));
    chk(tag, 32'(rsp_kind), 32'(e_kind));
    chk(tag, 32'(rsp_fault), 32'(e_flt));
    chk((e_nrd == 2) ? "R10" : tag, 32'(rsp_dom), 32'(e_dom));
    chk((e_nrd == 2) ? "R10" : tag, {30'd0, rsp_buf, rsp_cache}, {30'd0, e_b, e_c});
    chk("R1 l1 addr", a_log[0], {tb[31:14], va[31:20], 2'b00});
    chk("R5 reads", nrd - walk_start, e_nrd);
    if (e_nrd == 2) chk("R5 l2 addr", a_log[1], e_a2);
    @(negedge clk);
    chk("R12 pulse", {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  function automatic logic [31:0] mix(input int unsigned a, input int unsigned b);
    logic [31:0] h;
    h = a * 32'h9E3779B9 ^ (b * 32'h85EBCA6B) ^ 32'h5A17C3E1;
    h = h ^ (h >> 13);
    return h * 32'hC2B2AE35;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset idle", {29'd0, req_ready, rsp_valid, mem_req_valid}, 32'd4);
    rst_n = 1'b1;
    for (int s = 1; s <= 3; s++) begin
      smod = s;
      for (int i = 0; i < 6; i++)
        for (int k = 0; k < 4; k++)
          for (int v = 0; v < 5; v++)
            for (int t2 = 0; t2 < 4; t2++) begin
              logic [31:0] va, tb, d1, d2;
              va = (mix(i, k) & ~32'h0000CC00) | (32'(k) << 14) | (32'(k) << 10);
              tb = mix(i + 7, s);
              d1 = mix(i * 5 + v, t2 + 11) & ~32'h00040003;
              case (v)
                0: d1 = d1;
                1: d1 = d1 | 32'h1;
                2: d1 = d1 | 32'h2;
                3: d1 = d1 | 32'h00040002;
                default: d1 = d1 | 32'h3;
              endcase
              d2 = (mix(k + 3, i + v) & ~32'h3) | 32'(t2);
              walk(va, tb, d1, d2);
            end
    end
    checks++;
    if (hold_fail != 0) begin
      errors++;
      $display("FAIL R11 hold violations act=%0d exp=0", hold_fail);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule